// File: doc/BRIEF.md
# DRAM Strobe Decoder with Refresh Counter

This block models, on the device side, the control section of a DRAM with a multiplexed address bus. A system clock samples the active-low row strobe, column strobe, write enable and output enable. The block finds their edges and sorts each memory cycle into one of five kinds: read, early write, read-modify-write, refresh of the row on the address pins, or refresh of the row held in an internal counter. The last kind is chosen when the column strobe is already low at the moment the row strobe falls.

The block latches a row index from the address bus when a row opens. It latches a column index on each column strobe fall while the row stays open, so page-mode runs of columns are served within one row. It issues single-cycle strobes for array read, array write and row refresh. For refresh cycles that use the counter, the counter supplies the row. Read data coming back from an attached array is held on the data output past the end of the column strobe, in the manner of extended-data-out parts. The row and column widths are parameters, which cover both the 12/10-bit geometry and the 11/11-bit geometry.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While reset is asserted and just after it is released, all strobes are low, `cycType` is 0, `dqEn` is low and the refresh counter is 0.
- R2: A row strobe fall that is sampled while the column strobe was high on the previous clock opens a row. From the next clock, `rowIdx` holds the low ROW_BITS bits of `addr`.
- R3: A column strobe fall in an open row, with `weN` high, latches `colIdx` from `addr` and gives a one-cycle `arrRead` pulse with `cycType` = 1 on the next clock.
- R4: A column strobe fall with `weN` low (early write) gives a one-cycle `arrWrite` pulse with `cycType` = 2, and turns the data output off.
- R5: A fall of `weN` while the column strobe has been low for a read column gives one `arrWrite` pulse for that same row and column, with `cycType` = 3.
- R6: Further column strobe falls while the row strobe stays low each latch a new column and give a new strobe. `rowIdx` does not change.
- R7: A row strobe rise in an open row that saw no column strobe fall gives one `rowRefresh` pulse for the latched row. `cycType` = 4 for that one clock.
- R8: A row strobe fall while the column strobe was already low gives one `rowRefresh` pulse with `rowIdx` taken from the refresh counter, whatever is on `addr`. `cycType` = 5 is held until both strobes are high.
- R9: The refresh counter advances by one after each counter-based refresh and wraps from 2^ROW_BITS-1 to 0. No other cycle moves it.
- R10: The `rdData` present during an `arrRead` cycle appears on `dq` on the next clock. `dqEn` then stays high while `oeN` is low, including after the column strobe rises. `dqEn` drops while `oeN` is high, and drops for good once both strobes are sampled high.
- R11: `cycType` returns to 0 on the clock after both strobes are sampled high, unless that clock classifies a refresh of the pins' row.
- R12: At most one of `arrRead`, `arrWrite` and `rowRefresh` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | max(ROW_BITS,COL_BITS) | Multiplexed row/column address |
| rdData | input | DATA_BITS | Read data returned by the attached array for `rowIdx`/`colIdx` |
| rowIdx | output | ROW_BITS | Decoded row index |
| colIdx | output | COL_BITS | Decoded column index |
| cycType | output | 3 | 0 idle, 1 read, 2 write, 3 read-modify-write, 4 pin-row refresh, 5 counter refresh |
| arrRead | output | 1 | One-cycle array read strobe |
| arrWrite | output | 1 | One-cycle array write strobe |
| rowRefresh | output | 1 | One-cycle row refresh strobe |
| dq | output | DATA_BITS | Held read data |
| dqEn | output | 1 | Data output drive enable |

## Verification
Two functions can act on one clock edge. First, the data hold register loads a read word on the edge that follows `arrRead`. If the next column access in the page is an early write, its clear lands on the edge where the write strobe rises. The bench runs a read, then an early write within the same page, and expects `dqEn` low right after the write pulse. Second, the refresh counter steps on the same edge that copies its old value into `rowIdx`. The scoreboard therefore expects the pre-increment value in every counter refresh of a full wrap run.

// File: rtl/dram_strobe_pkg.sv
package dram_strobe_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_READ  = 3'd1,
    CYC_WRITE = 3'd2,
    CYC_RMW   = 3'd3,
    CYC_RREF  = 3'd4,
    CYC_CREF  = 3'd5
  } cycKind_e;

  // Actions the control asks of the datapath on the coming edge
  typedef struct packed {
    logic loadRow;   // capture a row index
    logic useCnt;    // row comes from the refresh counter, which then steps
    logic loadCol;   // capture a column index
    logic clrData;   // drop the held read data
  } dpCtl_t;

endpackage

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
  import dram_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  output dpCtl_t     ctl,
  output logic       arrRead,
  output logic       arrWrite,
  output logic       rowRefresh,
  output logic [2:0] cycType
);

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_CBR} ctlState_e;

  ctlState_e state;
  logic rasQ, casQ, weQ;
  logic colSeen, colIsRead;

  logic rasFall, rasRise, casFall, weFall;
  logic cbrStart, rowOpen, colAcc, colRd, colWr, rmwHit, rasOnly, bothHigh;
  cycKind_e cycNext;

  always_comb begin
    rasFall  = rasQ & ~rasN;
    rasRise  = ~rasQ & rasN;
    casFall  = casQ & ~casN;
    weFall   = weQ & ~weN;
    bothHigh = rasN & casN;
    cbrStart = (state == ST_IDLE) & rasFall & ~casQ;
    rowOpen  = (state == ST_IDLE) & rasFall & casQ;
    colAcc   = (state == ST_OPEN) & ~rasN & casFall;
    colRd    = colAcc & weN;
    colWr    = colAcc & ~weN;
    rmwHit   = (state == ST_OPEN) & ~rasN & ~casN & ~casQ & weFall & colIsRead;
    rasOnly  = (state == ST_OPEN) & rasRise & ~colSeen;

    ctl.loadRow = rowOpen | cbrStart;
    ctl.useCnt  = cbrStart;
    ctl.loadCol = colAcc;
    ctl.clrData = bothHigh | colWr;

    if (cbrStart)      cycNext = CYC_CREF;
    else if (rasOnly)  cycNext = CYC_RREF;
    else if (rmwHit)   cycNext = CYC_RMW;
    else if (colWr)    cycNext = CYC_WRITE;
    else if (colRd)    cycNext = CYC_READ;
    else if (bothHigh) cycNext = CYC_IDLE;
    else               cycNext = cycKind_e'(cycType);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ       <= 1'b1;
      casQ       <= 1'b1;
      weQ        <= 1'b1;
      state      <= ST_IDLE;
      colSeen    <= 1'b0;
      colIsRead  <= 1'b0;
      arrRead    <= 1'b0;
      arrWrite   <= 1'b0;
      rowRefresh <= 1'b0;
      cycType    <= 3'd0;
    end else begin
      rasQ       <= rasN;
      casQ       <= casN;
      weQ        <= weN;
      arrRead    <= colRd;
      arrWrite   <= colWr | rmwHit;
      rowRefresh <= cbrStart | rasOnly;
      cycType    <= cycNext;
      unique case (state)
        ST_IDLE: begin
          if (cbrStart) state <= ST_CBR;
          else if (rowOpen) begin
            state     <= ST_OPEN;
            colSeen   <= 1'b0;
            colIsRead <= 1'b0;
          end
        end
        ST_OPEN: begin
          if (rasRise) state <= ST_IDLE;
          if (colAcc) begin
            colSeen   <= 1'b1;
            colIsRead <= weN;
          end else if (rmwHit) begin
            colIsRead <= 1'b0;
          end
        end
        default: if (rasRise) state <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrRead, arrWrite, rowRefresh}));

  assert_cbr_refresh_R8: assert property (@(posedge clk) disable iff (!rstN)
    cbrStart |=> (rowRefresh && cycType == 3'd5));

  assert_ras_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    rasOnly |=> (rowRefresh && cycType == 3'd4));

  assert_rmw_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    rmwHit |=> (arrWrite && cycType == 3'd3));

endmodule

// File: rtl/dram_strobe_dp.sv
module dram_strobe_dp
  import dram_strobe_pkg::*;
#(
  parameter int ROW_BITS  = 12,
  parameter int COL_BITS  = 10,
  parameter int DATA_BITS = 4,
  parameter int ADDR_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic                 arrRead,
  input  logic [DATA_BITS-1:0] rdData,
  input  logic                 oeN,
  output logic [ROW_BITS-1:0]  rowIdx,
  output logic [COL_BITS-1:0]  colIdx,
  output logic [DATA_BITS-1:0] dq,
  output logic                 dqEn
);

  logic [ROW_BITS-1:0] refCnt;
  logic                holdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowIdx <= '0;
      colIdx <= '0;
      refCnt <= '0;
      dq     <= '0;
      holdQ  <= 1'b0;
    end else begin
      if (ctl.loadRow) rowIdx <= ctl.useCnt ? refCnt : ROW_BITS'(addr);
      if (ctl.useCnt)  refCnt <= refCnt + 1'b1;
      if (ctl.loadCol) colIdx <= COL_BITS'(addr);
      if (arrRead) begin
        dq    <= rdData;
        holdQ <= 1'b1;
      end else if (ctl.clrData) begin
        holdQ <= 1'b0;
      end
    end
  end

  assign dqEn = holdQ & ~oeN;

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.useCnt |=> (refCnt == $past(refCnt) + 1'b1));

  assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.useCnt |=> $stable(refCnt));

  assert_edo_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    arrRead |=> (holdQ && dq == $past(rdData)));

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dram_strobe_pkg::*;
#(
  parameter int ROW_BITS  = 12,
  parameter int COL_BITS  = 10,
  parameter int DATA_BITS = 4,
  localparam int ADDR_BITS = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic                 oeN,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DATA_BITS-1:0] rdData,
  output logic [ROW_BITS-1:0]  rowIdx,
  output logic [COL_BITS-1:0]  colIdx,
  output logic [2:0]           cycType,
  output logic                 arrRead,
  output logic                 arrWrite,
  output logic                 rowRefresh,
  output logic [DATA_BITS-1:0] dq,
  output logic                 dqEn
);

  dpCtl_t ctl;

  dram_strobe_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .ctl        (ctl),
    .arrRead    (arrRead),
    .arrWrite   (arrWrite),
    .rowRefresh (rowRefresh),
    .cycType    (cycType)
  );

  dram_strobe_dp #(
    .ROW_BITS  (ROW_BITS),
    .COL_BITS  (COL_BITS),
    .DATA_BITS (DATA_BITS),
    .ADDR_BITS (ADDR_BITS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addr    (addr),
    .arrRead (arrRead),
    .rdData  (rdData),
    .oeN     (oeN),
    .rowIdx  (rowIdx),
    .colIdx  (colIdx),
    .dq      (dq),
    .dqEn    (dqEn)
  );

  assert_dq_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rasN && casN) |=> !dqEn);

endmodule

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;

  localparam int ROW_BITS = 12;
  localparam int COL_BITS = 10;
  localparam int DATA_BITS = 4;
  localparam int ADDR_BITS = 12;

  typedef struct {
    int    kind;   // 0 read, 1 write, 2 refresh
    int    row;
    int    col;
    int    typ;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, casN = 1'b1, weN = 1'b1, oeN = 1'b0;
  logic [ADDR_BITS-1:0] addr = '0;
  logic [DATA_BITS-1:0] rdData;
  logic [ROW_BITS-1:0]  rowIdx;
  logic [COL_BITS-1:0]  colIdx;
  logic [2:0]           cycType;
  logic arrRead, arrWrite, rowRefresh, dqEn;
  logic [DATA_BITS-1:0] dq;

  int checks = 0;
  int errors = 0;
  expItem_t expQ[$];
  logic [ROW_BITS-1:0] expCnt = '0;

  always #4 clk = ~clk;

  function automatic logic [DATA_BITS-1:0] arrData(input int row, input int col);
    return DATA_BITS'(row ^ col ^ (row >> 4));
  endfunction

  assign rdData = arrData(int'(rowIdx), int'(colIdx));

  dram_strobe_decoder #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_BITS(DATA_BITS)) u0 (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addr(addr), .rdData(rdData), .rowIdx(rowIdx), .colIdx(colIdx),
    .cycType(cycType), .arrRead(arrRead), .arrWrite(arrWrite),
    .rowRefresh(rowRefresh), .dq(dq), .dqEn(dqEn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input int kind, input int row, input int col, input int typ, input string req);
    expItem_t it;
    it.kind = kind; it.row = row; it.col = col; it.typ = typ; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: pops one expected item per strobe pulse
  always @(posedge clk) begin
    #2;
    if (rstN && (arrRead || arrWrite || rowRefresh)) begin
      int kindAct;
      kindAct = arrRead ? 0 : (arrWrite ? 1 : 2);
      if (expQ.size() == 0) begin
        chk(1'b0, "R12 unexpected strobe", kindAct, -1);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(kindAct == it.kind, it.req, kindAct, it.kind);
        chk(int'(rowIdx) == it.row, it.req, int'(rowIdx), it.row);
        chk(int'(cycType) == it.typ, it.req, int'(cycType), it.typ);
        if (it.kind != 2) chk(int'(colIdx) == it.col, it.req, int'(colIdx), it.col);
      end
    end
  end

  task automatic rasOpen(input int row);
    addr = ADDR_BITS'(row); rasN = 1'b0; tick();
  endtask
  task automatic colRead(input int row, input int col, input string req);
    push(0, row, col, 1, req);
    addr = ADDR_BITS'(col); weN = 1'b1; casN = 1'b0; tick();
  endtask
  task automatic colWrite(input int row, input int col, input string req);
    push(1, row, col, 2, req);
    addr = ADDR_BITS'(col); weN = 1'b0; casN = 1'b0; tick();
  endtask
  task automatic casUp();
    casN = 1'b1; weN = 1'b1; tick();
  endtask
  task automatic rasUp();
    rasN = 1'b1; tick();
  endtask
  task automatic cbrCycle(input int junk);
    push(2, int'(expCnt), 0, 5, "R8/R9 counter refresh");
    expCnt = expCnt + 1'b1;
    casN = 1'b0; tick();
    addr = ADDR_BITS'(junk); rasN = 1'b0; tick();
    rasN = 1'b1; casN = 1'b1; tick();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(); tick();
    chk(!arrRead && !arrWrite && !rowRefresh, "R1 strobes in reset", {arrRead, arrWrite, rowRefresh}, 0);
    chk(cycType == 3'd0 && !dqEn, "R1 idle in reset", {cycType, dqEn}, 0);
    rstN = 1'b1; tick();
    chk(cycType == 3'd0 && !dqEn, "R1 idle after release", {cycType, dqEn}, 0);

    // R2, R3, R10: read with data hold
    rasOpen('h123);
    chk(rowIdx == 'h123, "R2 row latch", int'(rowIdx), 'h123);
    colRead('h123, 'h2A, "R3 read");
    tick();
    chk(dqEn && dq == arrData('h123, 'h2A), "R10 read data", int'(dq), int'(arrData('h123, 'h2A)));
    casUp(); tick();
    chk(dqEn && dq == arrData('h123, 'h2A), "R10 data held after column strobe rise", int'(dq), int'(arrData('h123, 'h2A)));
    // R6: page mode, same row
    colRead('h123, 'h155, "R6 page column");
    tick();
    chk(dq == arrData('h123, 'h155), "R6 page data", int'(dq), int'(arrData('h123, 'h155)));
    oeN = 1'b1; #1;
    chk(!dqEn, "R10 output enable off", dqEn, 0);
    oeN = 1'b0; #1;
    chk(dqEn, "R10 output enable back on", dqEn, 1);
    casUp();
    chk(cycType == 3'd1, "R11 type held while row open", int'(cycType), 1);
    rasUp();
    chk(cycType == 3'd0, "R11 type back to idle", int'(cycType), 0);
    chk(!dqEn, "R10 data off when both strobes high", dqEn, 0);

    // R4: early write after a read in the same page clears the held data
    rasOpen('h0F0);
    colRead('h0F0, 'h10, "R4 read before write");
    tick(); casUp();
    chk(dqEn, "R4 data held before write", dqEn, 1);
    colWrite('h0F0, 'h11, "R4 early write");
    chk(!dqEn, "R4 data off after early write", dqEn, 0);
    casUp(); rasUp();

    // R5: read-modify-write
    rasOpen('h777);
    colRead('h777, 'h0AA, "R5 read part");
    tick();
    push(1, 'h777, 'h0AA, 3, "R5 modify write");
    weN = 1'b0; tick();
    tick();
    chk(cycType == 3'd3, "R5 type held", int'(cycType), 3);
    casUp(); rasUp();

    // R7: refresh of the row on the pins
    rasOpen('h5A5);
    tick();
    push(2, 'h5A5, 0, 4, "R7 pin-row refresh");
    rasN = 1'b1; tick();
    tick();
    chk(cycType == 3'd0, "R7 type lasts one clock", int'(cycType), 0);

    // R8: counter refresh ignores addr, type held while strobes low
    push(2, int'(expCnt), 0, 5, "R8 counter refresh");
    expCnt = expCnt + 1'b1;
    casN = 1'b0; tick();
    addr = 'hABC; rasN = 1'b0; tick();
    tick();
    chk(cycType == 3'd5, "R8 type held", int'(cycType), 5);
    rasN = 1'b1; casN = 1'b1; tick();
    chk(cycType == 3'd0, "R11 idle after counter refresh", int'(cycType), 0);

    // R9: full wrap of the counter, rows checked by the scoreboard
    for (int i = 0; i < (1 << ROW_BITS); i++) cbrCycle(i ^ 'h5C3);
    chk(expCnt == 1, "R9 model wrapped", int'(expCnt), 1);
    cbrCycle('hFFF);

    tick(); tick();
    chk(expQ.size() == 0, "R12 all strobes seen", expQ.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule